// File: doc/BRIEF.md
# Strobe Receive Gate Controller

This block decides which strobe edges may reach the read-capture logic. A receive-enable pulse from the serializer opens the gate. While the gate is open, the incoming strobe passes through unchanged. While it is closed, the output is held low, so ringing or noise on an idle strobe line never looks like a capture edge. The strobe is treated as a digital level that a fast clock samples. Its falling edges are found by comparing each sample with the one before.

Closing does not simply follow the enable. A shortened copy of the enable falls one clock before the registered enable does. A half-burst counter advances on every strobe falling edge while the gate is open. The gate shuts only on a falling strobe edge that arrives while the shortened enable is low and the counter sits at its last value. This lets the final burst finish before the gate shuts. If the enable returns before that edge, as in back-to-back reads, the gate stays open without a gap.

Top module: `dqs_gate_ctrl`

## Requirements
- R1: A synchronous active-high reset closes the gate and clears the burst counter. `gate_open` and `strobe_gated` read 0 during reset and after it, whatever `strobe_in` does.
- R2: While the gate is closed, `strobe_gated` is 0, so strobe pulses outside a read window produce no output edge.
- R3: When `rx_en` is first sampled high at clock edge E0 and is still high at edge E1, `gate_open` is 0 after E0 and 1 after E1.
- R4: While `gate_open` is 1, `strobe_gated` equals `strobe_in` in every cycle.
- R5: A strobe falling edge is a sample of 0 on `strobe_in` that follows a sample of 1. The shortened enable is `rx_en` ANDed with `rx_en` delayed by one clock.
- R6: While the gate is open, the burst counter advances by one on each strobe falling edge. It wraps modulo BURST_LEN/2, so it runs 0, 1, 0, 1 for BURST_LEN = 4. It holds 0 while the gate is closed.
- R7: The gate closes on the clock edge that sees a strobe falling edge while the shortened enable is low and the counter is at BURST_LEN/2 - 1. `gate_open` is 0 after that edge.
- R8: Suppose `rx_en` drops right after the first falling edge of a burst. The gate then stays open through the rest of that burst, and exactly BURST_LEN/2 rising edges of that burst appear on `strobe_gated`.
- R9: Suppose `rx_en` drops and returns before the counter reaches its last value. The gate then stays open, so later bursts pass without a gap.
- R10: `gate_open` falls only in the cycle after a strobe falling edge, so the gate never cuts a strobe high phase short.

Other than reset, the only way to close the gate is a strobe falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable from the serializer |
| strobe_in | input | 1 | Raw strobe, sampled |
| strobe_gated | output | 1 | Strobe passed through the gate, low when the gate is closed |
| gate_open | output | 1 | High while the gate is open |

## Verification
The assertions take several things for granted about the inputs:
- `rx_en` rises at least two clocks before the first rising strobe edge of a read, which is the one-cycle preamble.
- The strobe delivers whole bursts of BURST_LEN/2 periods.
- A returning enable comes back before the closing falling edge.

The bench keeps within these limits. It drives every input on the falling clock edge and raises the enable two clocks ahead of the first strobe high. It only drops the enable in the low phase straight after a burst's first falling edge. When it re-raises the enable, it does so in the following cycle. It then sweeps the strobe half-period, the number of bursts and the burst in which the enable drops.

// File: rtl/dqs_gate_pkg.sv
package dqs_gate_pkg;

    // Gate states. DRAIN: enable has dropped, waiting for the last falling
    // edge of the current burst.
    typedef enum logic [1:0] {
        GATE_SHUT  = 2'd0,
        GATE_OPEN  = 2'd1,
        GATE_DRAIN = 2'd2
    } gate_state_e;

    function automatic int half_burst(input int burst_len);
        return burst_len / 2;
    endfunction

    function automatic int count_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/strobe_fall_det.sv
module strobe_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic strobe_in,
    output logic fall
);
    logic strobe_q;

    always_ff @(posedge clk) begin
        if (rst) strobe_q <= 1'b0;
        else     strobe_q <= strobe_in;
    end

    // R5: a low sample that follows a high sample
    assign fall = strobe_q & ~strobe_in;

endmodule

// File: rtl/enable_shaper.sv
module enable_shaper (
    input  logic clk,
    input  logic rst,
    input  logic rx_en,
    output logic mod_en
);
    logic en_d;

    always_ff @(posedge clk) begin
        if (rst) en_d <= 1'b0;
        else     en_d <= rx_en;
    end

    // R5: rises together with the registered enable, falls one clock sooner
    assign mod_en = rx_en & en_d;

    a_r5_mod_en_early_drop: assert property (@(posedge clk) disable iff (rst)
        (en_d && !rx_en) |-> !mod_en);

endmodule

// File: rtl/half_burst_counter.sv
module half_burst_counter #(
    parameter int HALF  = 2,
    parameter int CNT_W = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic fall,
    output logic at_max
);
    localparam logic [CNT_W-1:0] MAX_V = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (!active) cnt <= '0;
        else if (fall)    cnt <= (cnt == MAX_V) ? '0 : cnt + CNT_W'(1);
    end

    assign at_max = (cnt == MAX_V);

    a_r6_within_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= MAX_V);
    a_r6_zero_when_shut: assert property (@(posedge clk) disable iff (rst)
        !active |-> cnt == '0);
    a_r6_hold_without_fall: assert property (@(posedge clk) disable iff (rst)
        (active && !fall) |=> $stable(cnt));

endmodule

// File: rtl/gate_fsm.sv
module gate_fsm
    import dqs_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        mod_en,
    input  logic        fall,
    input  logic        at_max,
    output gate_state_e state
);
    gate_state_e nxt;
    logic        finish;

    // R7: close only on the last falling edge of a burst with enable low
    assign finish = fall & at_max & ~mod_en;

    always_comb begin
        nxt = state;
        unique case (state)
            GATE_SHUT:  if (mod_en) nxt = GATE_OPEN;
            GATE_OPEN:  if (finish) nxt = GATE_SHUT;
                        else if (!mod_en) nxt = GATE_DRAIN;
            GATE_DRAIN: if (mod_en) nxt = GATE_OPEN;      // R9
                        else if (finish) nxt = GATE_SHUT;
            default:    nxt = GATE_SHUT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= GATE_SHUT;
        else     state <= nxt;
    end

    a_r7_no_close_while_enabled: assert property (@(posedge clk) disable iff (rst)
        (state != GATE_SHUT && mod_en) |=> state != GATE_SHUT);
    a_r8_close_needs_last_edge: assert property (@(posedge clk) disable iff (rst)
        (state != GATE_SHUT && !(fall && at_max)) |=> state != GATE_SHUT);

endmodule

// File: rtl/dqs_gate_ctrl.sv
module dqs_gate_ctrl
    import dqs_gate_pkg::*;
#(
    parameter int BURST_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_en,
    input  logic strobe_in,
    output logic strobe_gated,
    output logic gate_open
);
    localparam int HALF  = half_burst(BURST_LEN);
    localparam int CNT_W = count_width(HALF);

    logic        fall;
    logic        mod_en;
    logic        at_max;
    gate_state_e state;

    strobe_fall_det u_fall (
        .clk       (clk),
        .rst       (rst),
        .strobe_in (strobe_in),
        .fall      (fall)
    );

    enable_shaper u_shape (
        .clk    (clk),
        .rst    (rst),
        .rx_en  (rx_en),
        .mod_en (mod_en)
    );

    half_burst_counter #(
        .HALF  (HALF),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .active (gate_open),
        .fall   (fall),
        .at_max (at_max)
    );

    gate_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .mod_en (mod_en),
        .fall   (fall),
        .at_max (at_max),
        .state  (state)
    );

    assign gate_open    = (state != GATE_SHUT);
    // R2 / R4: pass while open, hold low while shut
    assign strobe_gated = strobe_in & gate_open;

    initial begin
        a_r6_even_burst: assert (BURST_LEN >= 2 && BURST_LEN % 2 == 0);
    end

    a_r3_opens_after_two_edges: assert property (@(posedge clk) disable iff (rst)
        (!gate_open && rx_en && $past(rx_en) && !$past(rst)) |=> gate_open);
    a_r3_open_needs_enable: assert property (@(posedge clk) disable iff (rst)
        ($rose(gate_open) && !$past(rst)) |-> $past(rx_en));
    a_r9_steady_enable_keeps_open: assert property (@(posedge clk) disable iff (rst)
        (gate_open && rx_en && $past(rx_en) && !$past(rst)) |=> gate_open);
    a_r10_close_after_fall: assert property (@(posedge clk) disable iff (rst)
        ($fell(gate_open) && !$past(rst)) |-> (!$past(strobe_in) && $past(strobe_in, 2)));

endmodule

// File: tb/tb_dqs_gate_ctrl.sv
module tb_dqs_gate_ctrl;
    localparam int BL   = 4;
    localparam int HALF = BL / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_en = 1'b0;
    logic strobe_in = 1'b0;
    logic strobe_gated;
    logic gate_open;

    int  checks = 0;
    int  errors = 0;
    int  rises = 0;
    int  follow_err = 0;
    logic prev_g = 1'b0;
    bit  done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    dqs_gate_ctrl #(.BURST_LEN(BL)) dut (
        .clk          (clk),
        .rst          (rst),
        .rx_en        (rx_en),
        .strobe_in    (strobe_in),
        .strobe_gated (strobe_gated),
        .gate_open    (gate_open)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // advance to the next falling clock edge and sample the outputs
    task automatic step();
        @(negedge clk);
        if (strobe_gated && !prev_g) rises++;
        prev_g = strobe_gated;
        if (gate_open && (strobe_gated !== strobe_in)) follow_err++;
        if (!gate_open && strobe_gated) follow_err++;
    endtask

    task automatic idle(input int n);
        rx_en = 1'b0;
        strobe_in = 1'b0;
        repeat (n) step();
    endtask

    task automatic run_case(input int h, input int nb, input int dj, input bit b2b);
        int expect_r;
        rises = 0;
        follow_err = 0;
        prev_g = 1'b0;
        rx_en = 1'b1;
        step();
        check(gate_open == 1'b0, "R3 shut after first edge", int'(gate_open), 0);
        step();
        check(gate_open == 1'b1, "R3 open after second edge", int'(gate_open), 1);
        for (int b = 0; b < nb; b++) begin
            for (int p = 0; p < HALF; p++) begin
                strobe_in = 1'b1;
                repeat (h) step();
                strobe_in = 1'b0;
                if (p == 0 && (b == dj || (b2b && b == nb - 1))) rx_en = 1'b0;
                step();
                if (b2b && p == 0 && b == dj) rx_en = 1'b1;  // R9 re-raise
                repeat (h - 1) step();
            end
        end
        // trailing ringing after the read
        rx_en = 1'b0;
        for (int k = 0; k < 3; k++) begin
            strobe_in = 1'b1; step();
            strobe_in = 1'b0; step();
        end
        step();
        expect_r = b2b ? HALF * nb : HALF * (dj + 1);
        // R6 R8 R9: whole bursts pass, R2: nothing after closing
        check(rises == expect_r, $sformatf("R8 R9 edge count h=%0d nb=%0d dj=%0d b2b=%0d", h, nb, dj, b2b),
              rises, expect_r);
        check(gate_open == 1'b0, "R7 gate shut after final burst", int'(gate_open), 0);
        check(follow_err == 0, "R4 R2 gated output mismatch cycles", follow_err, 0);
        idle(3);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state with a toggling strobe
        for (int k = 0; k < 4; k++) begin
            strobe_in = k[0];
            rx_en = 1'b1;
            @(negedge clk);
            check(gate_open == 1'b0 && strobe_gated == 1'b0, "R1 reset holds shut",
                  int'({gate_open, strobe_gated}), 0);
        end
        rx_en = 1'b0;
        strobe_in = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        idle(2);
        check(gate_open == 1'b0, "R1 shut after reset", int'(gate_open), 0);

        // R2: noise with no enable
        rises = 0;
        for (int k = 0; k < 10; k++) begin
            strobe_in = 1'b1; step();
            strobe_in = 1'b0; step();
        end
        check(rises == 0, "R2 noise blocked", rises, 0);
        check(gate_open == 1'b0, "R2 gate stays shut", int'(gate_open), 0);

        // sweep: half-period, burst count, drop point, back-to-back
        for (int h = 1; h <= 3; h++)
            for (int nb = 1; nb <= 4; nb++)
                for (int dj = 0; dj < nb; dj++) begin
                    run_case(h, nb, dj, 1'b0);
                    if (dj < nb - 1) run_case(h, nb, dj, 1'b1);
                end

        // R1: reset while open
        rx_en = 1'b1;
        step(); step();
        check(gate_open == 1'b1, "R3 open before reset", int'(gate_open), 1);
        strobe_in = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        check(gate_open == 1'b0 && strobe_gated == 1'b0, "R1 reset closes open gate",
              int'({gate_open, strobe_gated}), 0);
        rst = 1'b0;
        rx_en = 1'b0;
        strobe_in = 1'b0;
        idle(2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule